// File: doc/BRIEF.md
# SPI Register-Access Master

This block turns a local register command into one SPI frame aimed at a remote register bridge. A command carries a direction flag, a register address and, for writes, a data word. Within a single chip-select window the block sends the address field and then either sends the write data or collects read data from MISO. A one-cycle completion pulse marks the end of the frame. For a read, the returned word is on the read-data output in that same cycle.

Each SPI bit lasts `RATIO` system clocks. The serial clock is low for the first half of the bit and high for the second half, so it rests low. The most significant position of the `ADDR_W`-bit address field holds the direction flag: 1 means write, 0 means read. The `ADDR_W-1` address bits follow it. The `DATA_W`-bit data field comes right after, with no turnaround gap. The slave updates MISO on falling serial-clock edges, and the master samples MISO on rising ones. `RATIO` must be even and at least 4 so that a slave that synchronises the serial clock through three flops can still see every edge.

The controller has three states. `ST_IDLE` waits for a command. `ST_FRAME` holds chip select low and shifts bits. `ST_GAP` keeps chip select high for one bit period. The transitions are: IDLE→FRAME when a start is accepted, FRAME→GAP at the end of the last bit period, and GAP→IDLE at the end of the gap period.

Top module: `spi_reg_master`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, mosi is 0, done is 0 and rdata is 0.
- R2: While cs_n is low, sclk is 0 for the first RATIO/2 system cycles of each bit period and 1 for the remaining RATIO/2 cycles.
- R3: Each frame holds cs_n low for exactly (ADDR_W+DATA_W)×RATIO consecutive system cycles.
- R4: The first MOSI bit of a frame is the direction flag (1 for write, 0 for read). The next ADDR_W-1 bits are addr, MSB first.
- R5: In a write frame, the DATA_W bits after the address field are wdata, MSB first.
- R6: In a read frame, MOSI is 0 for the whole data field.
- R7: In a read frame, the block samples MISO on the sclk rising edge of each data bit and assembles the bits MSB first. The result is presented on rdata in the done cycle, and rdata changes in no other cycle.
- R8: done is a single-cycle pulse, and it is high exactly in the first cycle in which cs_n is high again after a frame.
- R9: start is ignored unless the block is idle. A start held or pulsed during a frame or gap does not alter the running frame and does not start a frame on its own.
- R10: Between two frames, cs_n stays high for at least RATIO system cycles.
- R11: Whenever cs_n is high, sclk and mosi are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command request, taken only in idle |
| wr | input | 1 | Direction: 1 write, 0 read |
| addr | input | ADDR_W-1 | Register address |
| wdata | input | DATA_W | Write data |
| done | output | 1 | One-cycle end-of-frame pulse |
| rdata | output | DATA_W | Read data, updated on done of a read |
| cs_n | output | 1 | SPI chip select, active low |
| sclk | output | 1 | SPI serial clock, rests low |
| mosi | output | 1 | SPI data to slave |
| miso | input | 1 | SPI data from slave |

## Verification
Three things coincide in one cycle: chip select is released, done fires, and rdata takes the captured word. The last MISO sample lands only half a bit period before that cycle. Reads with alternating and all-zero/all-one return patterns exercise this boundary, and the monitor compares done, cs_n and rdata in the release cycle itself. A second collision is a start request arriving while a frame or gap is running. The driver holds start through each gap and injects a conflicting start mid-frame, and the scoreboard then confirms that the frame bits and the frame count are unchanged.

// File: rtl/spi_rm_pkg.sv
package spi_rm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FRAME = 2'd1,
        ST_GAP   = 2'd2
    } rm_state_e;
endpackage

// File: rtl/spi_rm_timer.sv
module spi_rm_timer #(
    parameter int RATIO = 8,
    parameter int NBITS = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         run,
    output logic [$clog2(NBITS+1)-1:0]   bit_idx,
    output logic                         mid,
    output logic                         second_half,
    output logic                         period_end,
    output logic                         last_bit
);
    localparam int PW = $clog2(RATIO);
    localparam int BW = $clog2(NBITS + 1);

    logic [PW-1:0] phase_q;
    logic [BW-1:0] bit_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            bit_q   <= '0;
        end else if (clear) begin
            phase_q <= '0;
            bit_q   <= '0;
        end else if (run) begin
            if (period_end) begin
                phase_q <= '0;
                bit_q   <= bit_q + BW'(1);
            end else begin
                phase_q <= phase_q + PW'(1);
            end
        end
    end

    assign bit_idx     = bit_q;
    assign mid         = run && (phase_q == PW'(RATIO / 2));
    assign second_half = (phase_q >= PW'(RATIO / 2));
    assign period_end  = run && (phase_q == PW'(RATIO - 1));
    assign last_bit    = (bit_q == BW'(NBITS - 1));
endmodule

// File: rtl/spi_rm_shift.sv
module spi_rm_shift #(
    parameter int NBITS = 16,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NBITS-1:0] tx_word,
    input  logic             shift,
    input  logic             cap,
    input  logic             miso,
    output logic             tx_msb,
    output logic [DW-1:0]    rx_word
);
    logic [NBITS-1:0] tx_q;
    logic [DW-1:0]    rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
            rx_q <= '0;
        end else if (load) begin
            tx_q <= tx_word;
            rx_q <= '0;
        end else begin
            if (shift) tx_q <= {tx_q[NBITS-2:0], 1'b0};
            if (cap)   rx_q <= {rx_q[DW-2:0], miso};
        end
    end

    assign tx_msb  = tx_q[NBITS-1];
    assign rx_word = rx_q;
endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int RATIO  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wr,
    input  logic [ADDR_W-2:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              cs_n,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);
    import spi_rm_pkg::*;

    localparam int FW = ADDR_W + DATA_W;
    localparam int BW = $clog2(FW + 1);

    generate
        if (RATIO < 4 || (RATIO % 2) != 0) begin : g_bad_ratio
            $error("RATIO must be even and at least 4");
        end
    endgenerate

    rm_state_e   state_q, state_d;
    logic        is_rd_q;
    logic [BW-1:0] bit_idx;
    logic        mid, second_half, period_end, last_bit;
    logic        tx_msb;
    logic [DATA_W-1:0] rx_word;
    logic        in_frame, accept, frame_end, t_clear, t_run, cap;

    assign in_frame  = (state_q == ST_FRAME);
    assign accept    = (state_q == ST_IDLE) && start;
    assign frame_end = in_frame && period_end && last_bit;
    assign t_clear   = (state_q == ST_IDLE) || frame_end;
    assign t_run     = (state_q != ST_IDLE);
    assign cap       = in_frame && mid && is_rd_q && (bit_idx >= BW'(ADDR_W));

    spi_rm_timer #(.RATIO(RATIO), .NBITS(FW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (t_clear),
        .run        (t_run),
        .bit_idx    (bit_idx),
        .mid        (mid),
        .second_half(second_half),
        .period_end (period_end),
        .last_bit   (last_bit)
    );

    spi_rm_shift #(.NBITS(FW), .DW(DATA_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .tx_word({wr, addr, (wr ? wdata : {DATA_W{1'b0}})}),
        .shift  (in_frame && period_end),
        .cap    (cap),
        .miso   (miso),
        .tx_msb (tx_msb),
        .rx_word(rx_word)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)                   state_d = ST_FRAME;
            ST_FRAME: if (period_end && last_bit)  state_d = ST_GAP;
            ST_GAP:   if (period_end)              state_d = ST_IDLE;
            default:                               state_d = ST_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done    <= 1'b0;
            rdata   <= '0;
            is_rd_q <= 1'b0;
        end else begin
            done <= frame_end;
            if (accept)               is_rd_q <= !wr;
            if (frame_end && is_rd_q) rdata   <= rx_word;
        end
    end

    assign cs_n = !in_frame;
    assign sclk = in_frame && second_half;
    assign mosi = in_frame && tx_msb;
endmodule

// File: rtl/spi_rm_chk.sv
module spi_rm_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int RATIO  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              sclk,
    input logic              mosi,
    input logic              done,
    input logic [DATA_W-1:0] rdata
);
    localparam int FCYC = (ADDR_W + DATA_W) * RATIO;
    localparam int LW   = $clog2(FCYC + 1) + 1;
    localparam int HW   = $clog2(RATIO + 1) + 1;

    logic          cs_q;
    logic [LW-1:0] low_q;
    logic [HW-1:0] hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q  <= 1'b1;
            low_q <= '0;
            hi_q  <= HW'(RATIO);
        end else begin
            cs_q <= cs_n;
            if (!cs_n) begin
                low_q <= cs_q ? LW'(1) : low_q + LW'(1);
                hi_q  <= '0;
            end else if (hi_q < HW'(RATIO)) begin
                hi_q <= hi_q + HW'(1);
            end
        end
    end

    AST_QUIET_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!sclk && !mosi)); // R11
    AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && !cs_q)); // R8
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_FRAME_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !cs_q) |-> (low_q == LW'(FCYC))); // R3
    AST_SCLK_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> !sclk); // R2
    AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rdata)); // R7
    AST_MIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (hi_q >= HW'(RATIO))); // R10
endmodule

bind spi_reg_master spi_rm_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RATIO(RATIO)) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .cs_n (cs_n),
    .sclk (sclk),
    .mosi (mosi),
    .done (done),
    .rdata(rdata)
);

// File: tb/sim_spi_reg_master.sv
module sim_spi_reg_master;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int R  = 8;
    localparam int FW = AW + DW;

    typedef struct {
        logic          wr;
        logic [AW-2:0] addr;
        logic [DW-1:0] data;
    } item_t;

    logic clk = 0, rst_n = 0, start = 0, wr = 0, miso = 0;
    logic [AW-2:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic done, cs_n, sclk, mosi;
    logic [DW-1:0] rdata;

    int checks = 0, errors = 0, pushed = 0, frames = 0;
    bit finished = 0;
    item_t q[$];

    spi_reg_master #(.ADDR_W(AW), .DATA_W(DW), .RATIO(R)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .wr(wr), .addr(addr),
        .wdata(wdata), .done(done), .rdata(rdata), .cs_n(cs_n),
        .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: push expectation, hold start until the frame begins
    task automatic txn(input logic w, input logic [AW-2:0] a, input logic [DW-1:0] d, input bit poke);
        item_t it;
        it.wr = w; it.addr = a; it.data = d;
        q.push_back(it);
        pushed++;
        @(negedge clk);
        start = 1; wr = w; addr = a; wdata = d;
        while (cs_n) @(negedge clk);
        start = 0;
        if (poke) begin
            // R9: conflicting request mid-frame
            repeat (20) @(negedge clk);
            start = 1; wr = !w; addr = ~a; wdata = ~d;
            repeat (3) @(negedge clk);
            start = 0;
        end
        while (!done) @(negedge clk);
    endtask

    // monitor / scoreboard / slave model
    initial begin
        bit prev_cs = 1, rel = 0, sclk_bad = 0, quiet_bad = 0, have = 0;
        int cyc = 0, gap = R;
        logic [FW-1:0] word;
        logic [FW-1:0] expw;
        item_t cur;
        forever begin
            @(negedge clk);
            if (!rst_n) begin prev_cs = 1; continue; end
            if (rel) begin
                chk(done == 0, "R8 done single cycle", done, 0);
                rel = 0;
            end
            if (!cs_n) begin
                if (prev_cs) begin
                    chk(gap >= R, "R10 gap", gap, R);
                    chk(!quiet_bad, "R11 quiet when deselected", quiet_bad, 0);
                    quiet_bad = 0;
                    frames++;
                    have = (q.size() > 0);
                    chk(have, "R9 unexpected frame", frames, pushed);
                    if (have) cur = q.pop_front();
                    cyc = 0; word = '0; sclk_bad = 0;
                end
                if (sclk !== ((cyc % R) >= R/2)) sclk_bad = 1;
                if ((cyc % R) == 0) begin
                    if (cyc / R >= AW && have && !cur.wr) miso = cur.data[DW-1-(cyc/R - AW)];
                    else miso = 0;
                end
                if ((cyc % R) == R/2) word = {word[FW-2:0], mosi};
                cyc++;
            end else begin
                if (sclk !== 0 || mosi !== 0) quiet_bad = 1;
                if (!prev_cs) begin
                    chk(cyc == FW*R, "R3 frame length", cyc, FW*R);
                    chk(!sclk_bad, "R2 sclk shape", sclk_bad, 0);
                    chk(done == 1, "R8 done at release", done, 1);
                    rel = 1; gap = 1;
                    if (have) begin
                        expw = {cur.wr, cur.addr, (cur.wr ? cur.data : {DW{1'b0}})};
                        chk(word[FW-1] == cur.wr, "R4 direction flag", word[FW-1], cur.wr);
                        chk(word[FW-2:DW] == cur.addr, "R4 address bits", word[FW-2:DW], cur.addr);
                        if (cur.wr) chk(word[DW-1:0] == cur.data, "R5 write data", word[DW-1:0], cur.data);
                        else begin
                            chk(word[DW-1:0] == 0, "R6 mosi zero in read", word[DW-1:0], 0);
                            chk(rdata == cur.data, "R7 read data", rdata, cur.data);
                        end
                    end
                end else gap++;
                miso = 0;
            end
            prev_cs = cs_n;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        @(negedge clk);
        chk(cs_n == 1 && sclk == 0 && mosi == 0 && done == 0 && rdata == 0,
            "R1 reset state", {cs_n, sclk, mosi, done}, 4'b1000);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk(cs_n == 1 && sclk == 0 && mosi == 0 && done == 0 && rdata == 0,
            "R1 idle after reset", {cs_n, sclk, mosi, done}, 4'b1000);
        txn(1, 7'h00, 8'h5A, 0);
        txn(1, 7'h7F, 8'hA5, 0);
        txn(0, 7'h00, 8'h5A, 0);
        txn(1, 7'h2A, 8'hFF, 1);
        txn(0, 7'h55, 8'h00, 0);
        txn(0, 7'h7F, 8'hFF, 1);
        txn(0, 7'h01, 8'hA5, 0);
        txn(1, 7'h01, 8'h00, 0);
        repeat (4*R) @(negedge clk);
        chk(frames == pushed && q.size() == 0, "R9 no extra frame", frames, pushed);
        chk(rdata == 8'hA5, "R7 rdata kept over write", rdata, 8'hA5);
        finished = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule